// File: doc/BRIEF.md
# FIFO-Driven Card Clock Gate

This block decides, cycle by cycle, whether the clock towards a memory card may keep running during a data transfer. It watches how full the transfer FIFO is. When data flows towards the card and the FIFO runs dry, it stops the card clock. When data flows from the card and the FIFO fills up, it also stops the clock. In both cases no bit is lost, because the card only moves data while its clock runs. The block sits next to the clock divider. The divider supplies a one-cycle tick marking the falling phase of the divided clock, and the gate only changes its enable on that tick, so the gated clock never sees a runt pulse.

The two directions restart differently. After an overrun stop on a read, the host must pop at least two FIFO entries before the clock may resume. After an underrun stop on a write, the FIFO must hold data again and software must pulse a start strobe. If the stopped write was open-ended, a sticky flag tells the command logic that only a stop-transmission command may follow. Dropping the transfer-active input clears all of this.

Top module: `card_clk_gate`

## Requirements
- R1: After reset, cardClkEn is 1, clkStopped is 0 and onlyStopCmd is 0.
- R2: In a cycle with divFall=1, xferActive=1, xferWrite=1 and fifoLevel=0 while running, cardClkEn goes to 0 and clkStopped to 1 from the next cycle on.
- R3: In a cycle with divFall=1, xferActive=1, xferWrite=0 and fifoLevel equal to FIFO_DEPTH while running, cardClkEn goes to 0 and clkStopped to 1 from the next cycle on.
- R4: cardClkEn and clkStopped change only in the cycle that follows a cycle with divFall=1, and clkStopped is always the inverse of cardClkEn.
- R5: After a read-side stop, hostRd pulses are counted (saturating at 2) only while stopped. The clock resumes at the first divFall cycle after the count has reached 2, and a single pulse never restarts it. The count clears when the clock restarts.
- R6: After a write-side stop, the clock resumes at a divFall cycle where fifoLevel is nonzero and swStart is either pulsed in that cycle or was pulsed earlier during the same stop. Data without a start, or a start with an empty FIFO, keeps it stopped. A swStart while running has no effect.
- R7: onlyStopCmd rises together with a write-side stop when openEnded=1, stays 1 after the clock restarts, and falls in the cycle after xferActive=0. A write-side stop with openEnded=0 leaves it 0.
- R8: With xferActive=0, no stop is ever taken, the read count and pending start clear, and a stopped gate returns to running at the next divFall cycle.
- R9: While running, a FIFO level that is neither empty on a write nor full on a read keeps cardClkEn at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xferActive | input | 1 | A data transfer is in progress |
| xferWrite | input | 1 | 1 = data flows to the card, 0 = from the card |
| openEnded | input | 1 | Current write has no preset length |
| fifoLevel | input | LVL_W | Entries currently held in the FIFO |
| hostRd | input | 1 | Host pops one FIFO entry this cycle |
| swStart | input | 1 | Software clock-start strobe |
| divFall | input | 1 | Falling-phase tick of the divided card clock |
| cardClkEn | output | 1 | Enable for the card clock |
| clkStopped | output | 1 | Card clock is held stopped |
| onlyStopCmd | output | 1 | Only a stop-transmission command may be issued |

## Verification
The main function is driven with directed sequences and then with a long random mix, and all outputs are compared every cycle with a behavioural model. The directed part separates the two stop causes (empty on write, full on read) from mid-level operation. It checks that one host read is not enough to resume but a second is, and that data alone or a start alone does not resume a write but both together do. It also checks that the open-ended flag outlives the restart and goes away only with transfer-active. The random phase moves divFall, level extremes and the strobes against each other, so that an enable change off the falling tick, or a start strobe honoured while running, shows up as a mismatch.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

  typedef enum logic [1:0] {
    GATE_RUN     = 2'd0,
    GATE_HOLD_RD = 2'd1,
    GATE_HOLD_WR = 2'd2
  } gateState_e;

  typedef struct packed {
    logic haltRd;
    logic haltWr;
    logic resume;
    logic clearAll;
  } gateStrobe_t;

endpackage

// File: rtl/ccg_ctrl.sv
module ccg_ctrl
  import ccg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        xferActive,
  input  logic        xferWrite,
  input  logic        divFall,
  input  logic        swStart,
  input  logic        fifoEmpty,
  input  logic        fifoFull,
  input  logic        rdEnough,
  input  logic        startArmed,
  output gateStrobe_t strb,
  output gateState_e  state
);

  gateState_e nextState;

  // All state moves are qualified by the falling-phase tick.
  always_comb begin
    strb      = '0;
    nextState = state;
    if (divFall) begin
      if (!xferActive) begin
        strb.clearAll = (state != GATE_RUN);
        nextState     = GATE_RUN;
      end else begin
        unique case (state)
          GATE_RUN: begin
            if (xferWrite && fifoEmpty) begin
              strb.haltWr = 1'b1;
              nextState   = GATE_HOLD_WR;
            end else if (!xferWrite && fifoFull) begin
              strb.haltRd = 1'b1;
              nextState   = GATE_HOLD_RD;
            end
          end
          GATE_HOLD_RD: begin
            if (rdEnough) begin
              strb.resume = 1'b1;
              nextState   = GATE_RUN;
            end
          end
          GATE_HOLD_WR: begin
            if ((startArmed || swStart) && !fifoEmpty) begin
              strb.resume = 1'b1;
              nextState   = GATE_RUN;
            end
          end
          default: nextState = GATE_RUN;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= GATE_RUN;
    else       state <= nextState;
  end

  // R4: state only moves after a falling-phase tick
  a_r4_state_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(state) |-> $past(divFall));

  // R5: leaving a read hold needs the drain count or the end of the transfer
  a_r5_rd_resume: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == GATE_HOLD_RD && state == GATE_RUN) |-> $past(rdEnough || !xferActive));

  // R8: no stop is taken while the transfer is inactive
  a_r8_no_halt_idle: assert property (@(posedge clk) disable iff (!rstN)
    !xferActive |-> !(strb.haltRd || strb.haltWr));

endmodule

// File: rtl/ccg_datapath.sv
module ccg_datapath
  import ccg_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int RD_RESUME  = 2,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xferActive,
  input  logic             openEnded,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic             hostRd,
  input  logic             swStart,
  input  logic             holdRd,
  input  logic             holdWr,
  input  gateStrobe_t      strb,
  output logic             fifoEmpty,
  output logic             fifoFull,
  output logic             rdEnough,
  output logic             startArmed,
  output logic             cardClkEn,
  output logic             onlyStopCmd
);

  localparam int CNT_W = $clog2(RD_RESUME + 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(RD_RESUME);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(FIFO_DEPTH);

  logic [CNT_W-1:0] rdCnt;

  assign fifoEmpty = (fifoLevel == '0);
  assign fifoFull  = (fifoLevel >= LVL_FULL);
  assign rdEnough  = (rdCnt >= CNT_SAT);

  // host pops seen while held on a full FIFO, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   rdCnt <= '0;
    else if (!xferActive || strb.resume)         rdCnt <= '0;
    else if (holdRd && hostRd && rdCnt < CNT_SAT) rdCnt <= rdCnt + 1'b1;
  end

  // a start strobe seen while held on an empty FIFO is remembered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           startArmed <= 1'b0;
    else if (!xferActive || strb.resume) startArmed <= 1'b0;
    else if (holdWr && swStart)          startArmed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          onlyStopCmd <= 1'b0;
    else if (!xferActive)               onlyStopCmd <= 1'b0;
    else if (strb.haltWr && openEnded)  onlyStopCmd <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               cardClkEn <= 1'b1;
    else if (strb.haltRd || strb.haltWr)     cardClkEn <= 1'b0;
    else if (strb.resume || strb.clearAll)   cardClkEn <= 1'b1;
  end

  // R5: drain count never passes its saturation value
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    rdCnt <= CNT_SAT);

  // R7: the stop-only flag appears only together with a stopped clock
  a_r7_flag_with_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(onlyStopCmd) |-> !cardClkEn);

  // R4: enable toggles only after a halt or release decision
  a_r4_en_by_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cardClkEn) |-> $past(strb.haltRd || strb.haltWr || strb.resume || strb.clearAll));

endmodule

// File: rtl/card_clk_gate.sv
module card_clk_gate
  import ccg_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int RD_RESUME  = 2,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             xferActive,
  input  logic             xferWrite,
  input  logic             openEnded,
  input  logic [LVL_W-1:0] fifoLevel,
  input  logic             hostRd,
  input  logic             swStart,
  input  logic             divFall,
  output logic             cardClkEn,
  output logic             clkStopped,
  output logic             onlyStopCmd
);

  gateStrobe_t strb;
  gateState_e  state;
  logic        fifoEmpty, fifoFull, rdEnough, startArmed;

  ccg_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .xferActive (xferActive),
    .xferWrite  (xferWrite),
    .divFall    (divFall),
    .swStart    (swStart),
    .fifoEmpty  (fifoEmpty),
    .fifoFull   (fifoFull),
    .rdEnough   (rdEnough),
    .startArmed (startArmed),
    .strb       (strb),
    .state      (state)
  );

  ccg_datapath #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .RD_RESUME  (RD_RESUME),
    .LVL_W      (LVL_W)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .xferActive  (xferActive),
    .openEnded   (openEnded),
    .fifoLevel   (fifoLevel),
    .hostRd      (hostRd),
    .swStart     (swStart),
    .holdRd      (state == GATE_HOLD_RD),
    .holdWr      (state == GATE_HOLD_WR),
    .strb        (strb),
    .fifoEmpty   (fifoEmpty),
    .fifoFull    (fifoFull),
    .rdEnough    (rdEnough),
    .startArmed  (startArmed),
    .cardClkEn   (cardClkEn),
    .onlyStopCmd (onlyStopCmd)
  );

  assign clkStopped = (state != GATE_RUN);

  // R4: status from the controller agrees with the enable from the datapath
  a_r4_status_match: assert property (@(posedge clk) disable iff (!rstN)
    clkStopped == !cardClkEn);

  // R8: an idle transfer releases the clock at the falling tick
  a_r8_idle_release: assert property (@(posedge clk) disable iff (!rstN)
    (!xferActive && divFall) |=> cardClkEn);

endmodule

// File: tb/test_card_clk_gate.sv
`timescale 1ns/1ps
module test_card_clk_gate;

  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          xferActive = 0, xferWrite = 0, openEnded = 0;
  logic [LW-1:0] fifoLevel = '0;
  logic          hostRd = 0, swStart = 0, divFall = 0;
  logic          cardClkEn, clkStopped, onlyStopCmd;

  int checks = 0, errors = 0;
  bit cmpOn = 0;

  always #10 clk = ~clk;

  card_clk_gate #(.FIFO_DEPTH(DEPTH), .RD_RESUME(2)) i_card_clk_gate (
    .clk(clk), .rstN(rstN), .xferActive(xferActive), .xferWrite(xferWrite),
    .openEnded(openEnded), .fifoLevel(fifoLevel), .hostRd(hostRd),
    .swStart(swStart), .divFall(divFall), .cardClkEn(cardClkEn),
    .clkStopped(clkStopped), .onlyStopCmd(onlyStopCmd)
  );

  // falling-phase tick every fourth cycle
  int divCnt = 0;
  always @(negedge clk) begin
    divCnt  = (divCnt + 1) % 4;
    divFall <= (divCnt == 0);
  end

  // behavioural reference: 0 running, 1 held on read, 2 held on write
  int mState, mNext, mCnt;
  bit mArmed, mOnly, mRes, mHaltWr;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mArmed = 0; mOnly = 0;
    end else begin
      mNext = mState; mRes = 0; mHaltWr = 0;
      if (divFall) begin
        if (!xferActive) mNext = 0;
        else if (mState == 0) begin
          if (xferWrite && fifoLevel == 0) begin mNext = 2; mHaltWr = 1; end
          else if (!xferWrite && fifoLevel == DEPTH) mNext = 1;
        end else if (mState == 1) begin
          if (mCnt >= 2) begin mNext = 0; mRes = 1; end
        end else begin
          if ((mArmed || swStart) && fifoLevel != 0) begin mNext = 0; mRes = 1; end
        end
      end
      if (!xferActive || mRes) mCnt = 0;
      else if (mState == 1 && hostRd && mCnt < 2) mCnt = mCnt + 1;
      if (!xferActive || mRes) mArmed = 0;
      else if (mState == 2 && swStart) mArmed = 1;
      if (!xferActive) mOnly = 0;
      else if (mHaltWr && openEnded) mOnly = 1;
      mState = mNext;
    end
  end

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {en,stopped,onlyStop} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (cmpOn)
      chk("R4", {cardClkEn, clkStopped, onlyStopCmd},
          {mState == 0, mState != 0, mOnly});
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseRd();
    hostRd = 1; @(negedge clk); hostRd = 0;
  endtask

  task automatic pulseStart();
    swStart = 1; @(negedge clk); swStart = 0;
  endtask

  bit done = 0;
  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    waitCyc(2);
    chk("R1", {cardClkEn, clkStopped, onlyStopCmd}, 3'b100);
    rstN = 1;
    waitCyc(1);
    cmpOn = 1;

    // R9: mid-level write keeps running
    xferActive = 1; xferWrite = 1; openEnded = 1; fifoLevel = 5;
    waitCyc(10);
    chk("R9", {cardClkEn, clkStopped, onlyStopCmd}, 3'b100);

    // R2 / R7: empty on open-ended write
    fifoLevel = 0;
    waitCyc(5);
    chk("R2", {cardClkEn, clkStopped, 1'b0}, 3'b010);
    chk("R7", {2'b00, onlyStopCmd}, 3'b001);

    // R6: start with empty FIFO is not enough, then data resumes
    pulseStart();
    waitCyc(8);
    chk("R6", {cardClkEn, clkStopped, 1'b0}, 3'b010);
    fifoLevel = 3;
    waitCyc(5);
    chk("R6", {cardClkEn, clkStopped, 1'b0}, 3'b100);
    chk("R7", {2'b00, onlyStopCmd}, 3'b001);

    // R8: transfer end clears the flag
    xferActive = 0;
    waitCyc(5);
    chk("R8", {cardClkEn, clkStopped, onlyStopCmd}, 3'b100);

    // R3 / R5: full on read, one pop is not enough, two are
    xferWrite = 0; openEnded = 0; fifoLevel = DEPTH; xferActive = 1;
    waitCyc(5);
    chk("R3", {cardClkEn, clkStopped, onlyStopCmd}, 3'b010);
    pulseRd();
    waitCyc(8);
    chk("R5", {cardClkEn, clkStopped, onlyStopCmd}, 3'b010);
    fifoLevel = DEPTH - 2;
    pulseRd();
    waitCyc(6);
    chk("R5", {cardClkEn, clkStopped, onlyStopCmd}, 3'b100);

    // R7 / R6 / R8: closed-ended write stop, data without start, then idle
    xferActive = 0; waitCyc(5);
    xferWrite = 1; fifoLevel = 0; xferActive = 1;
    waitCyc(5);
    chk("R7", {cardClkEn, clkStopped, onlyStopCmd}, 3'b010);
    fifoLevel = 4;
    waitCyc(8);
    chk("R6", {cardClkEn, clkStopped, onlyStopCmd}, 3'b010);
    xferActive = 0;
    waitCyc(5);
    chk("R8", {cardClkEn, clkStopped, onlyStopCmd}, 3'b100);

    // R6: start while running is ignored later
    xferActive = 1; fifoLevel = 6;
    pulseStart();
    fifoLevel = 0; waitCyc(5);
    fifoLevel = 2; waitCyc(8);
    chk("R6", {cardClkEn, clkStopped, onlyStopCmd}, 3'b010);
    xferActive = 0; waitCyc(5);

    // random mix, compared every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 40) == 0) xferActive = ~xferActive;
      if ($urandom_range(0, 60) == 0) xferWrite  = ~xferWrite;
      if ($urandom_range(0, 30) == 0) openEnded  = ~openEnded;
      case ($urandom_range(0, 5))
        0:       fifoLevel = 0;
        1:       fifoLevel = LW'(DEPTH);
        2:       fifoLevel = LW'($urandom_range(1, DEPTH - 1));
        default: ;
      endcase
      hostRd  = ($urandom_range(0, 5) == 0);
      swStart = ($urandom_range(0, 9) == 0);
    end
    hostRd = 0; swStart = 0;
    waitCyc(2);
    cmpOn = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule